// File: doc/BRIEF.md
# Unaligned Load Alignment Unit

This block sits between a processor's load/store port and a memory that can only be read or written as whole, aligned 4-byte words. It accepts one request at a time, either a load of 1, 2 or 4 bytes at any byte address or an atomic store-conditional of one word. It then runs the memory accesses that the request needs and returns a single response. If a load fits inside one memory word, the block reads that word once. If the load crosses a word boundary, it reads the word holding the first requested byte and then the word after it. It concatenates the two words little-endian, drops the unwanted leading bytes, keeps only the bytes that were asked for, and zero-extends the result to 32 bits.

A two-bit policy input chooses how misalignment is handled. In fix-up mode, misaligned loads are served by the two-read merge. In fault mode, a misaligned load causes no memory access and gets an alignment fault instead. In truncate mode, which serves 16-byte wide accesses, the low four address bits are silently cleared and the load proceeds with no indication. An atomic store-conditional whose address is not word aligned is never written to memory. It returns a store-failure flag, not a fault, whatever the policy.

The controller has six states. S_IDLE is the only state that accepts requests. When it accepts one, it moves to S_RD_LO for a load, to S_STORE for an aligned store-conditional, or straight to S_DONE for a faulting load or a rejected store-conditional. S_RD_LO issues the first read and moves to S_RD_HI when the load splits, otherwise to S_MERGE. S_RD_HI issues the second read and moves to S_MERGE. S_MERGE registers the merged result and moves to S_DONE. S_STORE issues the write and moves to S_DONE. S_DONE presents the response for one cycle and returns to S_IDLE.

Top module: `ualign_load_unit`

## Requirements
- R1: A load whose bytes all lie in one memory word issues exactly one read, at the word address (byte address with bits [1:0] cleared). The `done` pulse arrives 3 clock edges after the accepting edge.
- R2: A load that crosses a word boundary issues two reads on consecutive cycles: first at word address W, then at W+4. Result byte i is byte (k+i) of the 8-byte little-endian pair {second word, first word}, where k is the byte offset. The `done` pulse arrives 4 edges after acceptance.
- R3: A load splits only when offset plus size exceeds 4. The size encoding is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. A halfword at offset 1 takes one read, and a halfword at offset 3 takes two.
- R4: Results narrower than 32 bits are zero-extended: byte lanes at or above the access size read 0.
- R5: With policy 1 (fault), a load whose address is not a multiple of its size issues no memory access. Its `done` pulse comes 1 edge after acceptance, with `align_fault` high and `rsp_data` zero. A naturally aligned load under this policy behaves as in R1.
- R6: With policy 2 (truncate), address bits [3:0] of a load are treated as zero. The load takes one read at the truncated address, and `align_fault` stays low.
- R7: A store-conditional (`req_atomic`=1) at a word-aligned address issues exactly one write of `req_wdata` to that word. Its `done` pulse comes 2 edges after acceptance, with `sc_fail` low.
- R8: A store-conditional whose address has bits [1:0] non-zero issues no write. Its `done` pulse comes 1 edge after acceptance, with `sc_fail` high and `align_fault` low, under every policy.
- R9: `req_ready` is high only while the unit is idle. A request held on `req_valid` while the unit is busy is ignored: it causes no extra access and does not change the result.
- R10: `done`, `align_fault` and `sc_fail` are single-cycle pulses. The two flags are only ever high together with `done`.
- R11: Policy 3 behaves exactly like policy 0 (fix-up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | Load size: 0 byte, 1 halfword, 2/3 word |
| req_atomic | input | 1 | 1 = store-conditional, 0 = load |
| req_wdata | input | 32 | Store-conditional data |
| req_policy | input | 2 | 0 fix-up, 1 fault, 2 truncate, 3 fix-up |
| mem_rd | output | 1 | Memory read strobe, data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| done | output | 1 | Response valid for this cycle |
| rsp_data | output | 32 | Zero-extended load result, zero when not done |
| align_fault | output | 1 | Alignment fault, with `done` |
| sc_fail | output | 1 | Store-conditional failed, with `done` |

## Verification
Each of the six states leaves its own mark on the strobes, so a controller stuck in or skipping a state shows up within one or two cycles. It shows as a missing or extra `mem_rd` or `mem_wr` pulse, a second read address that is not the first plus four, or a `done` pulse whose distance from acceptance differs from the 1, 2, 3 or 4 edges fixed for its request class. A wrong latched offset or size, or a stale low word, passes the strobe checks but appears in `rsp_data` on the very `done` cycle of that load. A request wrongly accepted while busy shows up as a surplus read and a changed result before the next response.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

    // Misalignment handling policy selected per request
    typedef enum logic [1:0] {
        POL_FIXUP     = 2'd0,
        POL_FAULT     = 2'd1,
        POL_TRUNC     = 2'd2,
        POL_FIXUP_ALT = 2'd3
    } policy_e;

    // What the controller must do with an accepted request
    typedef enum logic [1:0] {
        ACT_LOAD      = 2'd0,
        ACT_FAULT     = 2'd1,
        ACT_SC_WRITE  = 2'd2,
        ACT_SC_REJECT = 2'd3
    } action_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD_LO = 3'd1,
        S_RD_HI = 3'd2,
        S_MERGE = 3'd3,
        S_STORE = 3'd4,
        S_DONE  = 3'd5
    } state_e;

endpackage

// File: rtl/ualign_decode.sv
module ualign_decode
    import ualign_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int TRUNC_BITS = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int CNT_W     = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              atomic,
    input  logic [1:0]        policy,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFF_W-1:0]  offset,
    output logic [CNT_W-1:0]  nbytes,
    output logic              split,
    output action_e           action
);

    localparam logic [ADDR_W-1:0] TRUNC_MASK = ~((ADDR_W'(1) << TRUNC_BITS) - ADDR_W'(1));

    policy_e           pol;
    logic [ADDR_W-1:0] eff_addr;
    logic [OFF_W-1:0]  size_mask;
    logic [CNT_W-1:0]  span;
    logic              misaligned;
    logic              sc_unaligned;

    always_comb begin
        pol = policy_e'(policy);

        // Byte count: 1, 2, or a full word for the two largest codes
        if (size >= 2'd2) nbytes = CNT_W'(WORD_BYTES);
        else              nbytes = CNT_W'(1) << size;

        // Truncation applies to loads only
        if (pol == POL_TRUNC && !atomic) eff_addr = addr & TRUNC_MASK;
        else                             eff_addr = addr;

        offset    = eff_addr[OFF_W-1:0];
        word_addr = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

        size_mask  = OFF_W'(nbytes - CNT_W'(1));
        misaligned = |(offset & size_mask);

        span  = CNT_W'(offset) + nbytes;
        split = (span > CNT_W'(WORD_BYTES));

        sc_unaligned = |addr[OFF_W-1:0];

        if (atomic) begin
            action = sc_unaligned ? ACT_SC_REJECT : ACT_SC_WRITE;
        end else if (pol == POL_FAULT && misaligned) begin
            action = ACT_FAULT;
        end else begin
            action = ACT_LOAD;
        end
    end

endmodule

// File: rtl/ualign_merge.sv
module ualign_merge #(
    parameter int WORD_BYTES = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int CNT_W     = OFF_W + 1,
    localparam int DW        = WORD_BYTES * 8
) (
    input  logic [DW-1:0]    lo_word,
    input  logic [DW-1:0]    hi_word,
    input  logic [OFF_W-1:0] offset,
    input  logic [CNT_W-1:0] nbytes,
    output logic [DW-1:0]    result
);

    logic [2*DW-1:0] pair;
    assign pair = {hi_word, lo_word};

    // One selector per result lane: lane i takes pair byte offset+i
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        logic [CNT_W-1:0] src;
        logic             keep;
        assign src  = CNT_W'(offset) + CNT_W'(i);
        assign keep = (CNT_W'(i) < nbytes);
        assign result[i*8 +: 8] = keep ? pair[src*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/ualign_ctrl.sv
module ualign_ctrl
    import ualign_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int CNT_W     = OFF_W + 1,
    localparam int DW        = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DW-1:0]     req_wdata,
    input  logic [ADDR_W-1:0] dec_word_addr,
    input  logic [OFF_W-1:0]  dec_offset,
    input  logic [CNT_W-1:0]  dec_nbytes,
    input  logic              dec_split,
    input  action_e           dec_action,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     mrg_lo,
    output logic [DW-1:0]     mrg_hi,
    output logic [OFF_W-1:0]  mrg_offset,
    output logic [CNT_W-1:0]  mrg_nbytes,
    input  logic [DW-1:0]     mrg_result,
    output logic              done,
    output logic [DW-1:0]     rsp_data,
    output logic              align_fault,
    output logic              sc_fail
);

    state_e            state_q, state_d;
    action_e           act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  nb_q;
    logic              split_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     lo_q;
    logic [DW-1:0]     result_q;
    logic              accept;

    assign accept = req_valid && (state_q == S_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (dec_action)
                        ACT_LOAD:      state_d = S_RD_LO;
                        ACT_SC_WRITE:  state_d = S_STORE;
                        ACT_FAULT:     state_d = S_DONE;
                        ACT_SC_REJECT: state_d = S_DONE;
                        default:       state_d = S_DONE;
                    endcase
                end
            end
            S_RD_LO: state_d = split_q ? S_RD_HI : S_MERGE;
            S_RD_HI: state_d = S_MERGE;
            S_MERGE: state_d = S_DONE;
            S_STORE: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Request and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= ACT_LOAD;
            addr_q   <= '0;
            off_q    <= '0;
            nb_q     <= '0;
            split_q  <= 1'b0;
            wdata_q  <= '0;
            lo_q     <= '0;
            result_q <= '0;
        end else begin
            if (accept) begin
                act_q    <= dec_action;
                addr_q   <= dec_word_addr;
                off_q    <= dec_offset;
                nb_q     <= dec_nbytes;
                split_q  <= dec_split;
                wdata_q  <= req_wdata;
                result_q <= '0;
            end
            if (state_q == S_RD_HI) lo_q <= mem_rdata;
            if (state_q == S_MERGE) result_q <= mrg_result;
        end
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_addr    = addr_q;
        mem_wdata   = wdata_q;
        done        = 1'b0;
        rsp_data    = '0;
        align_fault = 1'b0;
        sc_fail     = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_RD_LO: mem_rd = 1'b1;
            S_RD_HI: begin
                mem_rd   = 1'b1;
                mem_addr = addr_q + ADDR_W'(WORD_BYTES);
            end
            S_MERGE: ;
            S_STORE: mem_wr = 1'b1;
            S_DONE: begin
                done        = 1'b1;
                rsp_data    = result_q;
                align_fault = (act_q == ACT_FAULT);
                sc_fail     = (act_q == ACT_SC_REJECT);
            end
            default: ;
        endcase
    end

    // Merge operands: split loads pair the saved low word with the arriving high word
    assign mrg_lo     = split_q ? lo_q : mem_rdata;
    assign mrg_hi     = split_q ? mem_rdata : '0;
    assign mrg_offset = off_q;
    assign mrg_nbytes = nb_q;

endmodule

// File: rtl/ualign_load_unit.sv
module ualign_load_unit
    import ualign_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int TRUNC_BITS = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int CNT_W     = OFF_W + 1,
    localparam int DW        = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_atomic,
    input  logic [DW-1:0]     req_wdata,
    input  logic [1:0]        req_policy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic [DW-1:0]     rsp_data,
    output logic              align_fault,
    output logic              sc_fail
);

    logic [ADDR_W-1:0] dec_word_addr;
    logic [OFF_W-1:0]  dec_offset;
    logic [CNT_W-1:0]  dec_nbytes;
    logic              dec_split;
    action_e           dec_action;

    logic [DW-1:0]     mrg_lo, mrg_hi, mrg_result;
    logic [OFF_W-1:0]  mrg_offset;
    logic [CNT_W-1:0]  mrg_nbytes;

    ualign_decode #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .TRUNC_BITS(TRUNC_BITS)
    ) decode_i (
        .addr(req_addr), .size(req_size), .atomic(req_atomic), .policy(req_policy),
        .word_addr(dec_word_addr), .offset(dec_offset), .nbytes(dec_nbytes),
        .split(dec_split), .action(dec_action)
    );

    ualign_ctrl #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wdata(req_wdata),
        .dec_word_addr(dec_word_addr), .dec_offset(dec_offset),
        .dec_nbytes(dec_nbytes), .dec_split(dec_split), .dec_action(dec_action),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mrg_lo(mrg_lo), .mrg_hi(mrg_hi), .mrg_offset(mrg_offset),
        .mrg_nbytes(mrg_nbytes), .mrg_result(mrg_result),
        .done(done), .rsp_data(rsp_data),
        .align_fault(align_fault), .sc_fail(sc_fail)
    );

    ualign_merge #(
        .WORD_BYTES(WORD_BYTES)
    ) merge_i (
        .lo_word(mrg_lo), .hi_word(mrg_hi), .offset(mrg_offset),
        .nbytes(mrg_nbytes), .result(mrg_result)
    );

endmodule

// File: rtl/ualign_load_chk.sv
module ualign_load_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              align_fault,
    input logic              sc_fail
);

    localparam int OFF_W = $clog2(WORD_BYTES);

    p_word_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[OFF_W-1:0] == '0));

    p_second_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

    p_fault_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!$past(mem_rd) && !$past(mem_wr)));

    p_reject_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fail |-> (!$past(mem_wr) && !align_fault));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd && !mem_wr && !done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flags_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (align_fault || sc_fail) |-> done);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

endmodule

bind ualign_load_unit ualign_load_chk #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .done(done),
    .align_fault(align_fault), .sc_fail(sc_fail)
);

// File: tb/ualign_load_unit_tb.sv
module ualign_load_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_atomic = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_policy = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] rsp_data;
    logic        align_fault, sc_fail;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int base_rd = 0;
    logic [31:0] rd_log [2];
    logic [31:0] wr_addr_seen, wr_data_seen;

    always #10 clk = ~clk;

    ualign_load_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_atomic(req_atomic),
        .req_wdata(req_wdata), .req_policy(req_policy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .rsp_data(rsp_data),
        .align_fault(align_fault), .sc_fail(sc_fail)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd29 + 32'd11;
        return t[7:0];
    endfunction

    // Memory model: one-cycle read latency, logs accesses
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= {mbyte(mem_addr + 3), mbyte(mem_addr + 2),
                          mbyte(mem_addr + 1), mbyte(mem_addr)};
            if (rd_cnt - base_rd < 2) rd_log[rd_cnt - base_rd] = mem_addr;
            rd_cnt = rd_cnt + 1;
        end
        if (mem_wr) begin
            wr_cnt = wr_cnt + 1;
            wr_addr_seen = mem_addr;
            wr_data_seen = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issues one request; returns edges to done and the response
    task automatic issue(input logic [31:0] addr, input logic [1:0] size,
                         input logic [1:0] pol, input logic atomic, input logic [31:0] wd,
                         output int lat, output logic [31:0] data,
                         output logic flt, output logic scf);
        @(negedge clk);
        base_rd = rd_cnt;
        req_addr = addr; req_size = size; req_policy = pol;
        req_atomic = atomic; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_data; flt = align_fault; scf = sc_fail;
        @(negedge clk);
        check(!done && !align_fault && !sc_fail, "R10", "pulse width",
              {29'd0, done, align_fault, sc_fail}, 32'd0);
    endtask

    task automatic t_load(input logic [31:0] addr, input logic [1:0] size,
                          input logic [1:0] pol, input string req);
        int lat; logic [31:0] d; logic f, s;
        logic [31:0] eff, exp, w0; int n, nrd, rd0;
        eff = (pol == 2'd2) ? (addr & ~32'hF) : addr;
        n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        exp = '0;
        for (int i = 0; i < n; i++) exp[i*8 +: 8] = mbyte(eff + i);
        w0 = eff & ~32'h3;
        nrd = ((eff & 32'h3) + n > 4) ? 2 : 1;
        rd0 = rd_cnt;
        issue(addr, size, pol, 1'b0, '0, lat, d, f, s);
        check(d == exp, req, "load data", d, exp);
        check(rd_cnt - rd0 == nrd, req, "read count", rd_cnt - rd0, nrd);
        check(rd_log[0] == w0, req, "first read addr", rd_log[0], w0);
        if (nrd == 2) check(rd_log[1] == w0 + 4, req, "second read addr", rd_log[1], w0 + 4);
        check(lat == nrd + 2, req, "latency", lat, nrd + 2);
        check(!f && !s, req, "no flags", {f, s}, 0);
    endtask

    task automatic t_fault(input logic [31:0] addr, input logic [1:0] size);
        int lat; logic [31:0] d; logic f, s; int rd0;
        rd0 = rd_cnt;
        issue(addr, size, 2'd1, 1'b0, '0, lat, d, f, s);
        check(f && !s, "R5", "fault flag", {f, s}, 2);
        check(rd_cnt == rd0, "R5", "no read on fault", rd_cnt - rd0, 0);
        check(lat == 1 && d == 0, "R5", "fault latency/data", lat, 1);
    endtask

    task automatic t_sc(input logic [31:0] addr, input logic [1:0] pol, input logic [31:0] wd);
        int lat; logic [31:0] d; logic f, s; int wr0, rd0;
        wr0 = wr_cnt; rd0 = rd_cnt;
        issue(addr, 2'd2, pol, 1'b1, wd, lat, d, f, s);
        check(rd_cnt == rd0, "R7", "no read on store", rd_cnt - rd0, 0);
        if (addr[1:0] == 2'b00) begin
            check(wr_cnt - wr0 == 1, "R7", "write count", wr_cnt - wr0, 1);
            check(wr_addr_seen == addr && wr_data_seen == wd, "R7", "write data", wr_data_seen, wd);
            check(!s && !f && lat == 2, "R7", "sc ok response", lat, 2);
        end else begin
            check(wr_cnt == wr0, "R8", "no write when unaligned", wr_cnt - wr0, 0);
            check(s && !f, "R8", "sc_fail without fault", {f, s}, 1);
            check(lat == 1, "R8", "reject latency", lat, 1);
        end
    endtask

    task automatic t_busy();
        logic [31:0] exp; int rd0; int lat;
        exp = {mbyte(32'h104), mbyte(32'h103), mbyte(32'h102), mbyte(32'h101)};
        rd0 = rd_cnt;
        @(negedge clk);
        base_rd = rd_cnt;
        req_addr = 32'h101; req_size = 2'd2; req_policy = 2'd0;
        req_atomic = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h200; req_size = 2'd0;
        check(!req_ready, "R9", "ready low while busy", req_ready, 0);
        @(negedge clk);
        check(!req_ready, "R9", "ready low while busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 3;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(rsp_data == exp, "R9", "result unaffected", rsp_data, exp);
        @(negedge clk);
        check(rd_cnt - rd0 == 2 && req_ready, "R9", "no extra access", rd_cnt - rd0, 2);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mem_rd && !mem_wr, "R9", "reset state",
              {28'd0, req_ready, done, mem_rd, mem_wr}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done, "R9", "idle after reset", req_ready, 1);

        t_load(32'h0000_0040, 2'd2, 2'd0, "R1");
        t_load(32'h0000_0041, 2'd2, 2'd0, "R2");
        t_load(32'h0000_0052, 2'd2, 2'd0, "R2");
        t_load(32'h0000_0063, 2'd2, 2'd0, "R2");
        t_load(32'h0000_0071, 2'd1, 2'd0, "R3");
        t_load(32'h0000_0073, 2'd1, 2'd0, "R3");
        t_load(32'h0000_0083, 2'd0, 2'd0, "R4");
        t_load(32'h0000_0092, 2'd1, 2'd0, "R4");
        t_load(32'h0000_00A2, 2'd3, 2'd0, "R3");
        t_fault(32'h0000_0031, 2'd1);
        t_fault(32'h0000_0032, 2'd2);
        t_load(32'h0000_0034, 2'd2, 2'd1, "R5");
        t_load(32'h0000_0035, 2'd0, 2'd1, "R5");
        t_load(32'h0000_0127, 2'd2, 2'd2, "R6");
        t_load(32'h0000_013F, 2'd1, 2'd2, "R6");
        t_load(32'h0000_0143, 2'd2, 2'd3, "R11");
        t_sc(32'h0000_0300, 2'd0, 32'hCAFE_F00D);
        t_sc(32'h0000_0302, 2'd0, 32'h1234_5678);
        t_sc(32'h0000_0301, 2'd1, 32'h1111_2222);
        t_sc(32'h0000_0303, 2'd2, 32'h3333_4444);
        t_busy();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule